// File: doc/BRIEF.md
# Remote terminal message validation controller

This block runs one remote terminal message from the moment the word decoder reports a valid command word addressed to the terminal. It splits the command word into its fields. It raises a command strobe and a status-enable output. For receive commands, it checks each decoded data word against the expected count and against an inter-word gap limit. Each accepted data word produces one DMA request pulse. When the message completes correctly, the block asks the encoder to send the status word.

Two kinds of fault are kept apart:

- **Invalid message.** A gap between data words, a surplus data word, or a decoder word error is an invalid message. The block raises the message-error output, stops the message and withholds the status word.
- **Illegal command.** The host flags an illegal command by raising its illegal-command input inside a qualification window counted from command acceptance. The status word is still requested, with its message-error bit set. The message-error output and a sticky message-error latch are also set. For a receive command, DMA requests are withheld. For the inhibitable mode codes (2, 4, 5, 6, 7 and 18), the mode function is not executed.

Each command type has its own window length. All windows are cycle counts given as parameters. A fail-safe timer counts transmit-active cycles and raises a timer-on output at its limit. Each newly accepted command clears it.

Top module: `rt_msg_ctrl`

## Requirements
- R1: The command word is decoded with T/R in bit 10 (1 = transmit), subaddress/mode in bits 9:5 and word count/mode code in bits 4:0.
  - A subaddress of 0 or 31 selects a mode command, and `mc_code` then carries bits 4:0.
  - A non-mode receive command expects bits 4:0 data words, where 0 means 32.
  - A receive mode command with bit 4 set expects one data word.
  - Every other command expects none.
- R2: A high `cmd_valid` at a clock edge accepts the command, and it also restarts any message already in progress.
  - `cmd_strobe` is high for the first STB_LEN cycles after acceptance.
  - `status_en` is high from the first cycle after acceptance until the status request or an invalid-message stop.
- R3: While data words are still expected, each `dword_stb` yields one `dma_req` pulse in the next cycle. The exception is an illegal command (R7).
  - On the last expected word, `status_req` pulses in that same next cycle.
  - No status is requested before the count is reached.
- R4: If a receive message has words outstanding and GAP_LIM cycles pass without a data word, counted from acceptance or from the last word, the message is invalid. The same applies if `dword_err` arrives during the data phase.
  - `msg_err` and `msg_err_latch` go high in the next cycle.
  - No `status_req` follows, and `status_en` drops.
- R5: A data word that arrives for a command expecting no data words, before its status request, makes the message invalid, with the same outcome as R4.
- R6: If `ill_cmd` is high in any of the first WIN cycles after acceptance, the command is illegal.
  - WIN is MC_WIN for the inhibitable mode codes, TX_WIN for other transmit commands and RX_WIN for other receive commands.
  - An illegal command sets `msg_err` and `msg_err_latch` in the next cycle.
  - The status word is still requested, with `status_me` = 1. `status_me` holds until the next accepted command.
- R7: For an illegal receive command, no `dma_req` is produced for any of its data words.
- R8: A command that expects no data words raises `status_req` exactly WIN cycles after the first cycle following acceptance. WIN is as in R6.
- R9: Every mode command raises `mc_exec` together with its `status_req`. For codes 2, 4, 5, 6, 7 and 18, an illegal flag (R6) suppresses `mc_exec`. For other codes, the flag does not suppress it.
- R10: `ill_cmd` high only at or after cycle WIN following acceptance has no effect: `dma_req`, `status_me` and `msg_err` stay as for a legal command.
- R11: `timer_on` goes high after TX_LIMIT clock edges with `tx_active` high since the last accepted command. It stays high until the next accepted command, which clears it in the next cycle.
- R12: During and right after reset, every output is 0.
- R13: `msg_err` clears when the next command is accepted.
  - `msg_err_latch` holds until a `latch_clr` cycle, which clears it in the next cycle.
  - A new error in the same cycle as `latch_clr` takes priority, so the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoder: valid command word present this cycle |
| cmd_word | input | 16 | Decoded command word |
| dword_stb | input | 1 | Decoder: valid data word this cycle |
| dword_err | input | 1 | Decoder: faulty data word this cycle |
| ill_cmd | input | 1 | Host: current command is illegal |
| tx_active | input | 1 | Encoder is transmitting |
| latch_clr | input | 1 | Clear the message-error latch |
| cmd_strobe | output | 1 | Command strobe after acceptance |
| status_en | output | 1 | External status outputs enabled |
| dma_req | output | 1 | Store-request pulse per accepted data word |
| status_req | output | 1 | Request to transmit the status word |
| status_me | output | 1 | Message-error bit of the status word |
| mc_exec | output | 1 | Execute-mode-function pulse |
| mc_code | output | 5 | Mode code of the current command |
| msg_err | output | 1 | Message-error output |
| msg_err_latch | output | 1 | Sticky message-error latch |
| timer_on | output | 1 | Fail-safe transmit timer expired |

## Verification
Every result is registered once, so each result is due in a fixed cycle:

- `dma_req` appears in the cycle after its data word.
- A no-data status request appears exactly WIN cycles after the first post-acceptance cycle.
- The gap error appears GAP_LIM cycles after the last word.
- `timer_on` appears after the TX_LIMIT-th active edge.

Inputs are driven and outputs sampled at falling edges. The directed checks count falling edges from the one that follows acceptance and sample exactly on the due cycle and on the cycle before it.

The random messages are checked through pulse counters that are snapshotted before each message and compared a few idle cycles after it ends. The expected values come from bench functions that decode the command word independently. The illegal-flag position is swept across each window boundary.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RX   = 2'd2
    } msg_state_e;

    // Mode codes whose function the host can block with the illegal flag.
    function automatic logic code_inhibitable(input logic [4:0] c);
        case (c)
            5'd2, 5'd4, 5'd5, 5'd6, 5'd7, 5'd18: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rtm_cmd_decode.sv
module rtm_cmd_decode
    import rtm_pkg::*;
#(
    parameter int MC_WIN = 4,
    parameter int TX_WIN = 8,
    parameter int RX_WIN = 6,
    parameter int AW     = 5
) (
    input  logic [15:0]   cmd_word,
    output logic          is_mc,
    output logic          inh,
    output logic [4:0]    code,
    output logic [5:0]    nwords,
    output logic [AW-1:0] win
);

    logic       xmit;
    logic [4:0] sub;

    always_comb begin
        xmit  = cmd_word[10];
        sub   = cmd_word[9:5];
        code  = cmd_word[4:0];
        is_mc = (sub == 5'd0) || (sub == 5'd31);
        inh   = is_mc && code_inhibitable(code);

        if (is_mc) begin
            nwords = (!xmit && code[4]) ? 6'd1 : 6'd0;
        end else if (xmit) begin
            nwords = 6'd0;
        end else begin
            nwords = (code == 5'd0) ? 6'd32 : {1'b0, code};
        end

        if (inh) begin
            win = AW'(MC_WIN);
        end else if (xmit) begin
            win = AW'(TX_WIN);
        end else begin
            win = AW'(RX_WIN);
        end
    end

endmodule

// File: rtl/rtm_failsafe_timer.sv
module rtm_failsafe_timer #(
    parameter int TX_LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tx_active,
    output logic timer_on
);

    localparam int CW = $clog2(TX_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          on;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (restart) begin
            d.cnt = '0;
            d.on  = 1'b0;
        end else if (tx_active && !q.on) begin
            if (q.cnt == CW'(TX_LIMIT - 1)) begin
                d.on = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign timer_on = q.on;

endmodule

// File: rtl/rtm_msg_seq.sv
module rtm_msg_seq
    import rtm_pkg::*;
#(
    parameter int STB_LEN = 3,
    parameter int GAP_LIM = 16,
    parameter int AW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          dec_is_mc,
    input  logic          dec_inh,
    input  logic [4:0]    dec_code,
    input  logic [5:0]    dec_nwords,
    input  logic [AW-1:0] dec_win,
    input  logic          dword_stb,
    input  logic          dword_err,
    input  logic          ill_cmd,
    input  logic          latch_clr,
    output logic          cmd_strobe,
    output logic          status_en,
    output logic          dma_req,
    output logic          status_req,
    output logic          status_me,
    output logic          mc_exec,
    output logic [4:0]    mc_code,
    output logic          msg_err,
    output logic          msg_err_latch
);

    localparam int           GW   = $clog2(GAP_LIM + 1);
    localparam logic [AW-1:0] AMAX = {AW{1'b1}};

    typedef struct packed {
        msg_state_e    st;
        logic [AW-1:0] age;
        logic [AW-1:0] win;
        logic [GW-1:0] gap;
        logic [5:0]    left;
        logic          ill;
        logic          is_mc;
        logic          inh;
        logic [4:0]    code;
        logic          strobe;
        logic          sten;
        logic          dma;
        logic          sreq;
        logic          sme;
        logic          mexe;
        logic          merr;
        logic          latch;
    } seq_t;

    seq_t d, q;

    logic active, ill_now, do_fin, do_inv, set_latch;

    always_comb begin
        d         = q;
        d.dma     = 1'b0;
        d.sreq    = 1'b0;
        d.mexe    = 1'b0;
        do_fin    = 1'b0;
        do_inv    = 1'b0;
        set_latch = 1'b0;
        active    = (q.st != ST_IDLE);
        ill_now   = q.ill || (ill_cmd && active && (q.age < q.win));

        if (active) begin
            if (q.age != AMAX) begin
                d.age = q.age + 1'b1;
            end
            d.strobe = (int'(q.age) + 1) < STB_LEN;
            d.ill    = ill_now;
            if (ill_now && !q.ill) begin
                d.merr    = 1'b1;
                set_latch = 1'b1;
            end
            case (q.st)
                ST_WAIT: begin
                    if (dword_stb || dword_err) begin
                        do_inv = 1'b1;
                    end else if (q.age == q.win - 1'b1) begin
                        do_fin = 1'b1;
                    end
                end
                ST_RX: begin
                    if (dword_err) begin
                        do_inv = 1'b1;
                    end else if (dword_stb) begin
                        d.dma  = !ill_now;
                        d.left = q.left - 1'b1;
                        d.gap  = '0;
                        if (q.left == 6'd1) begin
                            do_fin = 1'b1;
                        end
                    end else if (q.gap == GW'(GAP_LIM - 1)) begin
                        do_inv = 1'b1;
                    end else begin
                        d.gap = q.gap + 1'b1;
                    end
                end
                default: ;
            endcase
        end else begin
            d.strobe = 1'b0;
        end

        if (do_fin) begin
            d.sreq = 1'b1;
            d.sme  = ill_now;
            d.mexe = q.is_mc && !(q.inh && ill_now);
            d.st   = ST_IDLE;
            d.sten = 1'b0;
        end

        if (do_inv) begin
            d.merr    = 1'b1;
            set_latch = 1'b1;
            d.dma     = 1'b0;
            d.st      = ST_IDLE;
            d.sten    = 1'b0;
        end

        if (set_latch) begin
            d.latch = 1'b1;
        end else if (latch_clr) begin
            d.latch = 1'b0;
        end

        if (cmd_valid) begin
            d.st     = (dec_nwords != 6'd0) ? ST_RX : ST_WAIT;
            d.age    = '0;
            d.win    = dec_win;
            d.gap    = '0;
            d.left   = dec_nwords;
            d.ill    = 1'b0;
            d.is_mc  = dec_is_mc;
            d.inh    = dec_inh;
            d.code   = dec_code;
            d.strobe = 1'b1;
            d.sten   = 1'b1;
            d.dma    = 1'b0;
            d.sreq   = 1'b0;
            d.mexe   = 1'b0;
            d.sme    = 1'b0;
            d.merr   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_strobe    = q.strobe;
    assign status_en     = q.sten;
    assign dma_req       = q.dma;
    assign status_req    = q.sreq;
    assign status_me     = q.sme;
    assign mc_exec       = q.mexe;
    assign mc_code       = q.code;
    assign msg_err       = q.merr;
    assign msg_err_latch = q.latch;

endmodule

// File: rtl/rt_msg_ctrl.sv
module rt_msg_ctrl #(
    parameter int STB_LEN  = 3,
    parameter int MC_WIN   = 4,
    parameter int TX_WIN   = 8,
    parameter int RX_WIN   = 6,
    parameter int GAP_LIM  = 16,
    parameter int TX_LIMIT = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        dword_stb,
    input  logic        dword_err,
    input  logic        ill_cmd,
    input  logic        tx_active,
    input  logic        latch_clr,
    output logic        cmd_strobe,
    output logic        status_en,
    output logic        dma_req,
    output logic        status_req,
    output logic        status_me,
    output logic        mc_exec,
    output logic [4:0]  mc_code,
    output logic        msg_err,
    output logic        msg_err_latch,
    output logic        timer_on
);

    localparam int MAXW1 = (MC_WIN > TX_WIN) ? MC_WIN : TX_WIN;
    localparam int MAXW2 = (MAXW1 > RX_WIN) ? MAXW1 : RX_WIN;
    localparam int MAXW  = (MAXW2 > STB_LEN) ? MAXW2 : STB_LEN;
    localparam int AW    = $clog2(MAXW + 1) + 1;

    logic          dec_is_mc;
    logic          dec_inh;
    logic [4:0]    dec_code;
    logic [5:0]    dec_nwords;
    logic [AW-1:0] dec_win;

    rtm_cmd_decode #(
        .MC_WIN(MC_WIN), .TX_WIN(TX_WIN), .RX_WIN(RX_WIN), .AW(AW)
    ) u_dec (
        .cmd_word(cmd_word),
        .is_mc   (dec_is_mc),
        .inh     (dec_inh),
        .code    (dec_code),
        .nwords  (dec_nwords),
        .win     (dec_win)
    );

    rtm_msg_seq #(
        .STB_LEN(STB_LEN), .GAP_LIM(GAP_LIM), .AW(AW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .dec_is_mc    (dec_is_mc),
        .dec_inh      (dec_inh),
        .dec_code     (dec_code),
        .dec_nwords   (dec_nwords),
        .dec_win      (dec_win),
        .dword_stb    (dword_stb),
        .dword_err    (dword_err),
        .ill_cmd      (ill_cmd),
        .latch_clr    (latch_clr),
        .cmd_strobe   (cmd_strobe),
        .status_en    (status_en),
        .dma_req      (dma_req),
        .status_req   (status_req),
        .status_me    (status_me),
        .mc_exec      (mc_exec),
        .mc_code      (mc_code),
        .msg_err      (msg_err),
        .msg_err_latch(msg_err_latch)
    );

    rtm_failsafe_timer #(
        .TX_LIMIT(TX_LIMIT)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cmd_valid),
        .tx_active(tx_active),
        .timer_on (timer_on)
    );

endmodule

// File: rtl/rt_msg_ctrl_chk.sv
module rt_msg_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       dword_stb,
    input logic       latch_clr,
    input logic       cmd_strobe,
    input logic       status_en,
    input logic       dma_req,
    input logic       status_req,
    input logic       status_me,
    input logic       mc_exec,
    input logic       msg_err,
    input logic       msg_err_latch,
    input logic       timer_on
);

    // R2: strobe starts only after an accepted command
    a_r2_strobe_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_strobe) |-> $past(cmd_valid));

    // R2: status enable is low when status is requested
    a_r2_en_drops: assert property (@(posedge clk) disable iff (!rst_n)
        status_req |-> !status_en);

    // R3: every store request follows a data word
    a_r3_dma_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(dword_stb));

    // R7: no store request while a message error stands
    a_r7_no_dma_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !msg_err);

    // R6: a status word with the error bit comes with the error output
    a_r6_me_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
        (status_req && status_me) |-> msg_err);

    // R6: a rising message error sets the latch
    a_r6_err_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_err) |-> msg_err_latch);

    // R9: mode execution only alongside a status request
    a_r9_exec_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        mc_exec |-> status_req);

    // R11: an accepted command clears the timer
    a_r11_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid) |-> !timer_on);

    // R13: the latch drops only after a clear request
    a_r13_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_err_latch) |-> $past(latch_clr));

endmodule

bind rt_msg_ctrl rt_msg_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .dword_stb    (dword_stb),
    .latch_clr    (latch_clr),
    .cmd_strobe   (cmd_strobe),
    .status_en    (status_en),
    .dma_req      (dma_req),
    .status_req   (status_req),
    .status_me    (status_me),
    .mc_exec      (mc_exec),
    .msg_err      (msg_err),
    .msg_err_latch(msg_err_latch),
    .timer_on     (timer_on)
);

// File: tb/rt_msg_ctrl_tb.sv
module rt_msg_ctrl_tb;

    localparam int STB_LEN  = 3;
    localparam int MC_WIN   = 4;
    localparam int TX_WIN   = 8;
    localparam int RX_WIN   = 6;
    localparam int GAP_LIM  = 16;
    localparam int TX_LIMIT = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        dword_stb = 1'b0;
    logic        dword_err = 1'b0;
    logic        ill_cmd = 1'b0;
    logic        tx_active = 1'b0;
    logic        latch_clr = 1'b0;
    logic        cmd_strobe, status_en, dma_req, status_req, status_me;
    logic        mc_exec, msg_err, msg_err_latch, timer_on;
    logic [4:0]  mc_code;

    int n_tests = 0;
    int n_fail  = 0;
    int n_sreq  = 0;
    int n_dma   = 0;
    int n_mexe  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    rt_msg_ctrl #(
        .STB_LEN(STB_LEN), .MC_WIN(MC_WIN), .TX_WIN(TX_WIN),
        .RX_WIN(RX_WIN), .GAP_LIM(GAP_LIM), .TX_LIMIT(TX_LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dword_stb(dword_stb), .dword_err(dword_err), .ill_cmd(ill_cmd),
        .tx_active(tx_active), .latch_clr(latch_clr), .cmd_strobe(cmd_strobe),
        .status_en(status_en), .dma_req(dma_req), .status_req(status_req),
        .status_me(status_me), .mc_exec(mc_exec), .mc_code(mc_code),
        .msg_err(msg_err), .msg_err_latch(msg_err_latch), .timer_on(timer_on)
    );

    always @(posedge clk) begin
        if (status_req) n_sreq++;
        if (dma_req)    n_dma++;
        if (mc_exec)    n_mexe++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // Expected-value model taken from the requirements
    function automatic bit f_is_mc(input logic [15:0] w);
        return (w[9:5] == 5'd0) || (w[9:5] == 5'd31);
    endfunction

    function automatic bit f_inh(input logic [15:0] w);
        if (!f_is_mc(w)) return 1'b0;
        return (w[4:0] == 5'd2) || (w[4:0] == 5'd4) || (w[4:0] == 5'd5) ||
               (w[4:0] == 5'd6) || (w[4:0] == 5'd7) || (w[4:0] == 5'd18);
    endfunction

    function automatic int f_words(input logic [15:0] w);
        if (f_is_mc(w)) return (!w[10] && w[4]) ? 1 : 0;
        if (w[10]) return 0;
        return (w[4:0] == 5'd0) ? 32 : int'(w[4:0]);
    endfunction

    function automatic int f_win(input logic [15:0] w);
        if (f_inh(w)) return MC_WIN;
        return w[10] ? TX_WIN : RX_WIN;
    endfunction

    // All tasks start and end at a falling edge
    task automatic send_cmd(input logic [15:0] w);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_word();
        dword_stb = 1'b1;
        @(negedge clk);
        dword_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full message with an illegal-flag pulse in cycle ill_at (-1: none)
    task automatic run_msg(input logic [15:0] w, input int ill_at, input string tag);
        int s0, d0, m0, nw, win, last;
        bit eff;
        s0   = n_sreq; d0 = n_dma; m0 = n_mexe;
        nw   = f_words(w);
        win  = f_win(w);
        eff  = (ill_at >= 0) && (ill_at < win);
        last = win + 2;
        send_cmd(w);
        for (int c = 0; c < last; c++) begin
            ill_cmd = (c == ill_at);
            @(negedge clk);
        end
        ill_cmd = 1'b0;
        for (int k = 0; k < nw; k++) send_word();
        idle(3);
        chk_eq({tag, " R3 status requests"}, n_sreq - s0, 1);
        chk_eq({tag, " R7 dma count"}, n_dma - d0, eff ? 0 : nw);
        chk_eq({tag, " R6 status me bit"}, int'(status_me), int'(eff));
        chk_eq({tag, " R6 msg_err"}, int'(msg_err), int'(eff));
        chk_eq({tag, " R9 mode exec"}, n_mexe - m0,
               int'(f_is_mc(w) && !(f_inh(w) && eff)));
        if (f_is_mc(w)) chk_eq({tag, " R1 mc_code"}, int'(mc_code), int'(w[4:0]));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        int s0, d0;
        void'($urandom(32'h1553_0042));
        idle(2);
        // R12: reset state
        chk_eq("R12 outputs in reset",
               int'({cmd_strobe, status_en, dma_req, status_req, status_me,
                     mc_exec, msg_err, msg_err_latch, timer_on}), 0);
        rst_n = 1'b1;
        idle(1);
        chk_eq("R12 outputs after reset",
               int'({cmd_strobe, status_en, dma_req, status_req, status_me,
                     mc_exec, msg_err, msg_err_latch, timer_on}), 0);

        // R2, R8: transmit command, sa 1, strobe length and status timing
        w = {5'd3, 1'b1, 5'd1, 5'd4};
        s0 = n_sreq;
        send_cmd(w);
        chk_eq("R2 strobe cycle0", int'(cmd_strobe), 1);
        chk_eq("R2 status_en cycle0", int'(status_en), 1);
        idle(STB_LEN - 1);
        chk_eq("R2 strobe last cycle", int'(cmd_strobe), 1);
        idle(1);
        chk_eq("R2 strobe ended", int'(cmd_strobe), 0);
        idle(TX_WIN - 1 - STB_LEN);
        chk_eq("R8 no status before window end", int'(status_req), 0);
        idle(1);
        chk_eq("R8 status at TX window", int'(status_req), 1);
        chk_eq("R2 status_en dropped", int'(status_en), 0);
        chk_eq("R9 no exec on non-mode", int'(mc_exec), 0);
        idle(2);
        chk_eq("R8 one status only", n_sreq - s0, 1);

        // R8, R9: inhibitable mode code 5 (sa 31), MC window, legal
        w = {5'd3, 1'b1, 5'd31, 5'd5};
        send_cmd(w);
        idle(MC_WIN - 1);
        chk_eq("R8 mode no status yet", int'(status_req), 0);
        idle(1);
        chk_eq("R8 mode status at MC window", int'(status_req), 1);
        chk_eq("R9 mode exec legal", int'(mc_exec), 1);
        idle(2);

        // R3, R1: receive with word count 0 -> 32 words
        w = {5'd3, 1'b0, 5'd2, 5'd0};
        s0 = n_sreq; d0 = n_dma;
        send_cmd(w);
        for (int k = 0; k < 31; k++) send_word();
        chk_eq("R1 no status after 31 of 32", n_sreq - s0, 0);
        chk_eq("R3 dma pulses for 31", n_dma - d0, 30);
        send_word();
        chk_eq("R3 dma on last word", int'(dma_req), 1);
        chk_eq("R3 status with last word", int'(status_req), 1);
        idle(2);
        chk_eq("R3 dma total 32", n_dma - d0, 32);

        // R6, R7, R10: receive window boundaries
        run_msg({5'd3, 1'b0, 5'd4, 5'd2}, RX_WIN - 1, "rx ill at win-1");
        run_msg({5'd3, 1'b0, 5'd4, 5'd2}, RX_WIN, "R10 rx ill at win");
        run_msg({5'd3, 1'b0, 5'd4, 5'd3}, 0, "rx ill at 0");
        // R9: inhibited code 2 versus non-inhibitable code 1
        run_msg({5'd3, 1'b1, 5'd0, 5'd2}, 0, "R9 code2 ill");
        run_msg({5'd3, 1'b1, 5'd0, 5'd2}, MC_WIN, "R10 code2 ill late");
        run_msg({5'd3, 1'b1, 5'd0, 5'd1}, 1, "R9 code1 ill");
        run_msg({5'd3, 1'b0, 5'd31, 5'd18}, MC_WIN - 1, "R9 code18 rx ill");

        // R4: gap timeout
        w = {5'd3, 1'b0, 5'd4, 5'd3};
        s0 = n_sreq;
        send_cmd(w);
        send_word();
        idle(GAP_LIM - 1);
        chk_eq("R4 no error before gap limit", int'(msg_err), 0);
        idle(1);
        chk_eq("R4 error at gap limit", int'(msg_err), 1);
        chk_eq("R4 latch set", int'(msg_err_latch), 1);
        chk_eq("R4 status_en dropped", int'(status_en), 0);
        idle(3);
        chk_eq("R4 no status after gap", n_sreq - s0, 0);

        // R13: new command clears msg_err, latch holds until clear
        w = {5'd3, 1'b1, 5'd1, 5'd1};
        send_cmd(w);
        chk_eq("R13 msg_err cleared by command", int'(msg_err), 0);
        chk_eq("R13 latch held", int'(msg_err_latch), 1);
        idle(TX_WIN + 2);
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
        chk_eq("R13 latch cleared", int'(msg_err_latch), 0);

        // R5: data word on a transmit command
        s0 = n_sreq;
        send_cmd({5'd3, 1'b1, 5'd1, 5'd2});
        send_word();
        chk_eq("R5 surplus word error", int'(msg_err), 1);
        idle(TX_WIN + 2);
        chk_eq("R5 no status", n_sreq - s0, 0);

        // R4: decoder word error during data
        s0 = n_sreq; d0 = n_dma;
        send_cmd({5'd3, 1'b0, 5'd4, 5'd3});
        send_word();
        dword_err = 1'b1;
        @(negedge clk);
        dword_err = 1'b0;
        chk_eq("R4 word error flagged", int'(msg_err), 1);
        send_word();
        idle(3);
        chk_eq("R4 no status after word error", n_sreq - s0, 0);
        chk_eq("R4 no dma after stop", n_dma - d0, 1);

        // R11: fail-safe timer
        tx_active = 1'b1;
        idle(TX_LIMIT - 1);
        chk_eq("R11 timer not yet", int'(timer_on), 0);
        idle(1);
        chk_eq("R11 timer on at limit", int'(timer_on), 1);
        tx_active = 1'b0;
        idle(2);
        chk_eq("R11 timer holds", int'(timer_on), 1);
        send_cmd({5'd3, 1'b1, 5'd1, 5'd1});
        chk_eq("R11 timer cleared by command", int'(timer_on), 0);
        idle(TX_WIN + 2);

        // Random messages
        for (int i = 0; i < 40; i++) begin
            int ia;
            w  = 16'($urandom);
            ia = ($urandom % 4 == 0) ? -1 : int'($urandom % (f_win(w) + 3));
            run_msg(w, ia, $sformatf("rand%0d", i));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule